// File: doc/BRIEF.md
# Transmit descriptor ring completion engine

This block runs one transmit descriptor ring. The descriptors sit in a small local memory that stands in for host memory. Software fills descriptors through a memory port, sets the ring size, turns the ring on, and moves a head index forward to hand work over. The engine keeps its own tail index. While the ring is enabled and tail differs from head, it takes the descriptor at tail and waits a fixed number of cycles that stands in for the payload transfer. It then writes the descriptor back with its completed flag set and advances tail. When the descriptor asked for an interrupt, the engine raises a one-cycle completion pulse.

Ownership of each descriptor moves through its flag bits. Software must mark a descriptor as posted before handing it over. The engine marks it completed when it is done. A descriptor at tail that is not marked posted is refused: tail does not move, and a sticky error output is set.

Descriptor word (32 bits): length in [31:16], start-of-frame in [15], end-of-frame in [14], and a zero field in [13:12]. Flags occupy [11:0], with isochronous at bit 0, completed at bit 1, posted at bit 2 and interrupt request at bit 3.

Top module: `txring_engine`

## Requirements
- R1: After reset, tail_o is 0, irq_o is 0 and err_o is 0. The ring is disabled, head is 0 and the descriptor count equals DEPTH.
- R2: The register at reg_addr_i=2 holds the enable flag in bit 31. While that flag is clear, no descriptor is processed, tail_o stays put and memory is not modified.
- R3: The register at reg_addr_i=0 holds the head index. The engine processes the descriptors from tail up to, but not including, head. The ring is empty, and the engine idles, when tail equals head.
- R4: The engine writes back each processed descriptor with bit 1 (completed) set. Every other bit of the word is left unchanged.
- R5: tail_o advances by one for each processed descriptor. After reaching count-1 it wraps to 0. The count is held in the register at reg_addr_i=1 and must lie between 1 and DEPTH.
- R6: irq_o is a one-cycle pulse. It fires once per processed descriptor that has bit 3 set, and never for a descriptor with bit 3 clear. It is high in the cycle right after the write-back edge, when memory already shows the completed flag.
- R7: A descriptor at tail with bit 2 (posted) clear is not processed. Tail stays unchanged and the word is not written. err_o is set and stays set until reset. Processing resumes once the descriptor is posted.
- R8: A descriptor's tail update lands LAT+2 clock edges after the edge that registers a head write making the ring non-empty. The irq_o pulse for that descriptor appears in the same cycle as the tail update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 head, 1 count, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| mem_we_i | input | 1 | Software descriptor write strobe |
| mem_addr_i | input | $clog2(DEPTH) | Software descriptor index |
| mem_wdata_i | input | 32 | Software descriptor write data |
| mem_rdata_o | output | 32 | Descriptor at mem_addr_i (combinational read) |
| tail_o | output | $clog2(DEPTH) | Engine tail index |
| irq_o | output | 1 | Completion pulse |
| err_o | output | 1 | Sticky unposted-descriptor error |

## Verification
The bench builds the engine with DEPTH=4 and LAT=3. The small depth lets random ring sizes from 1 to 4 wrap the tail several times within a few batches, including the case of a one-entry ring. The short latency keeps the exact cycle count of each tail update and pulse easy to check, while still leaving a multi-cycle transfer window. Random batches mix interrupt-request bits, lengths and frame markers; directed cases cover the disabled ring, the timing and the unposted descriptor.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int DESC_W = 32;
  localparam int FLG_ISO  = 0;
  localparam int FLG_DONE = 1;
  localparam int FLG_POST = 2;
  localparam int FLG_IRQ  = 3;
  localparam int CTRL_EN  = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_WB   = 2'd2
  } eng_state_e;

  typedef enum logic [1:0] {
    RA_HEAD  = 2'd0,
    RA_COUNT = 2'd1,
    RA_CTRL  = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/txring_mem.sv
module txring_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          sw_we_i,
  input  logic [IW-1:0] sw_addr_i,
  input  logic [DW-1:0] sw_wdata_i,
  output logic [DW-1:0] sw_rdata_o,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_addr_i,
  input  logic [DW-1:0] eng_wdata_i,
  output logic [DW-1:0] eng_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // software write wins a same-cycle collision
  always_ff @(posedge clk_i) begin
    if (sw_we_i && (int'(sw_addr_i) < DEPTH)) begin
      mem_q[sw_addr_i] <= sw_wdata_i;
    end else if (eng_we_i && (int'(eng_addr_i) < DEPTH)) begin
      mem_q[eng_addr_i] <= eng_wdata_i;
    end
  end

  assign sw_rdata_o  = mem_q[sw_addr_i];
  assign eng_rdata_o = mem_q[eng_addr_i];
endmodule

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [IW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      count_o <= CW'(DEPTH);
      en_o    <= 1'b0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        RA_HEAD:  head_o  <= wdata_i[IW-1:0];
        RA_COUNT: count_o <= wdata_i[CW-1:0];
        RA_CTRL:  en_o    <= wdata_i[CTRL_EN];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/txring_walker.sv
module txring_walker
  import txring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LAT   = 4,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [IW-1:0] head_i,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] rd_i,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic [IW-1:0] tail_o,
  output logic          irq_o,
  output logic          err_o
);
  eng_state_e    state_q;
  logic [LW-1:0] cnt_q;
  logic [CW-1:0] tail_inc;
  logic [IW-1:0] tail_nxt;
  logic          pending;

  assign pending  = en_i && (tail_o != head_i);
  assign tail_inc = CW'(tail_o) + CW'(1);
  assign tail_nxt = (tail_inc >= count_i) ? '0 : tail_inc[IW-1:0];
  assign we_o     = (state_q == ST_WB);
  assign wdata_o  = rd_i | (DW'(1) << FLG_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tail_o  <= '0;
      irq_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (pending) begin
            if (rd_i[FLG_POST]) begin
              state_q <= ST_XFER;
              cnt_q   <= '0;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (cnt_q == LW'(LAT - 1)) state_q <= ST_WB;
          else                       cnt_q   <= cnt_q + LW'(1);
        end
        ST_WB: begin
          tail_o  <= tail_nxt;
          irq_o   <= rd_i[FLG_IRQ];
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !en_i) |=> (state_q == ST_IDLE)); // R2
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && tail_o == head_i) |=> (state_q == ST_IDLE)); // R3
  AST_TAIL_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && count_i != '0 && $stable(count_i)) |=> (CW'(tail_o) < count_i)); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R6
  AST_IRQ_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(we_o)); // R6
  AST_WB_ONLY_POSTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> rd_i[FLG_POST]); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
  AST_XFER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER) |-> (int'(cnt_q) < LAT)); // R8
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LAT   = 4,
  localparam int DW   = DESC_W,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          mem_we_i,
  input  logic [IW-1:0] mem_addr_i,
  input  logic [DW-1:0] mem_wdata_i,
  output logic [DW-1:0] mem_rdata_o,
  output logic [IW-1:0] tail_o,
  output logic          irq_o,
  output logic          err_o
);
  logic [IW-1:0] head;
  logic [CW-1:0] count;
  logic          en;
  logic          eng_we;
  logic [DW-1:0] eng_wdata, eng_rdata;

  txring_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .head_o  (head),
    .count_o (count),
    .en_o    (en)
  );

  txring_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i,
    .sw_we_i     (mem_we_i),
    .sw_addr_i   (mem_addr_i),
    .sw_wdata_i  (mem_wdata_i),
    .sw_rdata_o  (mem_rdata_o),
    .eng_we_i    (eng_we),
    .eng_addr_i  (tail_o),
    .eng_wdata_i (eng_wdata),
    .eng_rdata_o (eng_rdata)
  );

  txring_walker #(.DEPTH(DEPTH), .LAT(LAT), .DW(DW)) u_walker (
    .clk_i, .rst_ni,
    .en_i    (en),
    .head_i  (head),
    .count_i (count),
    .rd_i    (eng_rdata),
    .we_o    (eng_we),
    .wdata_o (eng_wdata),
    .tail_o  (tail_o),
    .irq_o   (irq_o),
    .err_o   (err_o)
  );
endmodule

// File: tb/txring_engine_test.sv
module txring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int LAT   = 3;
  localparam int IW    = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_we_i = 1'b0;
  logic [IW-1:0] mem_addr_i = '0;
  logic [31:0] mem_wdata_i = '0;
  logic [31:0] mem_rdata_o;
  logic [IW-1:0] tail_o;
  logic        irq_o, err_o;

  int n_chk = 0, n_err = 0;
  int irq_total = 0, irq_double = 0;
  logic irq_prev = 1'b0;
  int exp_tail;
  logic [31:0] sent [DEPTH];

  txring_engine #(.DEPTH(DEPTH), .LAT(LAT)) uut (
    .clk_i(clk), .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .mem_we_i, .mem_addr_i, .mem_wdata_i, .mem_rdata_o,
    .tail_o, .irq_o, .err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (irq_o) irq_total++;
    if (irq_o && irq_prev) irq_double++;
    irq_prev = irq_o;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL R0 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_desc(logic [15:0] len, bit sof, bit eof, bit irq, bit post);
    return {len, sof, eof, 2'b00, 8'h00, irq, post, 1'b0, 1'b0};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    exp_tail = 0;
  endtask

  task automatic reg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic mem_wr(int idx, logic [31:0] d);
    @(negedge clk);
    mem_we_i = 1'b1; mem_addr_i = IW'(idx); mem_wdata_i = d;
    @(negedge clk);
    mem_we_i = 1'b0;
  endtask

  task automatic mem_rd(int idx, output logic [31:0] d);
    mem_addr_i = IW'(idx);
    #1;
    d = mem_rdata_o;
  endtask

  task automatic run_batch(int cnt, int n);
    int e_irq = 0;
    int base;
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      d = mk_desc(16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
      sent[i] = d;
      if (d[3]) e_irq++;
      mem_wr((exp_tail + i) % cnt, d);
    end
    base = irq_total;
    reg_wr(2'd0, 32'((exp_tail + n) % cnt));
    repeat (n * (LAT + 2) + 6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mem_rd((exp_tail + i) % cnt, d);
      check("R4 completed set, rest kept", d, sent[i] | 32'h2);
    end
    exp_tail = (exp_tail + n) % cnt;
    check("R5 tail advance and wrap", 32'(tail_o), 32'(exp_tail));
    check("R6 one pulse per irq request", 32'(irq_total - base), 32'(e_irq));
    check("R3 idle at head", 32'(irq_o), 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    int cnt;
    void'($urandom(32'd20240611));
    exp_tail = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 tail reset", 32'(tail_o), 32'h0);
    check("R1 irq reset", 32'(irq_o), 32'h0);
    check("R1 err reset", 32'(err_o), 32'h0);

    // R2 disabled ring does nothing
    mem_wr(0, mk_desc(16'h0040, 1, 0, 1, 1));
    mem_wr(1, mk_desc(16'h0080, 0, 1, 1, 1));
    reg_wr(2'd0, 32'd2);
    repeat (30) @(negedge clk);
    check("R2 tail held while disabled", 32'(tail_o), 32'h0);
    mem_rd(0, d);
    check("R2 memory untouched while disabled", d, mk_desc(16'h0040, 1, 0, 1, 1));
    check("R2 no pulse while disabled", 32'(irq_total), 32'h0);
    reg_wr(2'd2, 32'h8000_0000);
    repeat (2 * (LAT + 2) + 4) @(negedge clk);
    check("R2 enabled ring drains", 32'(tail_o), 32'h2);
    check("R6 two requested pulses", 32'(irq_total), 32'h2);

    // R8 exact timing of tail update and pulse
    do_reset();
    reg_wr(2'd2, 32'h8000_0000);
    mem_wr(0, mk_desc(16'h1234, 1, 1, 1, 1));
    reg_wr(2'd0, 32'd1);
    repeat (LAT + 1) @(negedge clk);
    check("R8 tail not yet moved", 32'(tail_o), 32'h0);
    check("R8 pulse not yet", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R8 tail moved at LAT+2", 32'(tail_o), 32'h1);
    check("R6 pulse with tail update", 32'(irq_o), 32'h1);
    mem_rd(0, d);
    check("R6 completed visible during pulse", d, mk_desc(16'h1234, 1, 1, 1, 1) | 32'h2);
    @(negedge clk);
    check("R6 pulse lasts one cycle", 32'(irq_o), 32'h0);

    // R6 no pulse without request
    mem_wr(1, mk_desc(16'h0010, 0, 0, 0, 1));
    cnt = irq_total;
    reg_wr(2'd0, 32'd2);
    repeat (LAT + 6) @(negedge clk);
    check("R6 no pulse without request", 32'(irq_total - cnt), 32'h0);
    check("R3 processed up to head", 32'(tail_o), 32'h2);

    // R7 unposted descriptor
    do_reset();
    reg_wr(2'd2, 32'h8000_0000);
    mem_wr(0, mk_desc(16'h0777, 1, 1, 1, 0));
    cnt = irq_total;
    reg_wr(2'd0, 32'd1);
    repeat (20) @(negedge clk);
    check("R7 tail held on unposted", 32'(tail_o), 32'h0);
    check("R7 err raised", 32'(err_o), 32'h1);
    mem_rd(0, d);
    check("R7 unposted word not written", d, mk_desc(16'h0777, 1, 1, 1, 0));
    check("R7 no pulse on unposted", 32'(irq_total - cnt), 32'h0);
    mem_wr(0, mk_desc(16'h0777, 1, 1, 1, 1));
    repeat (LAT + 6) @(negedge clk);
    check("R7 resumes once posted", 32'(tail_o), 32'h1);
    check("R7 err sticky", 32'(err_o), 32'h1);

    // R5 random ring sizes and batches with wrap
    for (int it = 0; it < 8; it++) begin
      do_reset();
      check("R1 err cleared by reset", 32'(err_o), 32'h0);
      cnt = 1 + int'($urandom % DEPTH);
      reg_wr(2'd1, 32'(cnt));
      reg_wr(2'd2, 32'h8000_0000);
      for (int b = 0; b < 4; b++) begin
        if (cnt > 1) run_batch(cnt, 1 + int'($urandom % (cnt - 1)));
        else check("R3 one-entry ring stays empty", 32'(tail_o), 32'h0);
      end
    end

    check("R6 never two cycles high", 32'(irq_double), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule